// File: doc/BRIEF.md
# Bus-Master DMA Window Address Translator

This block sits between a peripheral bus and host memory and turns each bus-master DMA address into a host physical address. A handful of programmable windows each claim a slice of the bus address space. A window in direct mode adds a fixed host offset to the address. A window in scatter-gather mode splits the address into an 8 KB page number and a byte offset. It then uses the page number to pick an entry from a page table held in a local SRAM, and the entry supplies the host page frame.

The page table is written through its own write port and is shared by every window. A four-entry, fully associative cache keeps recently used table entries. Every table write is snooped against the cache, so software never has to issue an invalidate. Requests come in on a valid/ready port. Each accepted request returns exactly one response that carries either a host address or an error flag. The response comes one cycle after acceptance for direct windows, cache hits and misses of every window. It comes one cycle later when the page-table SRAM must be read.

Top module: `dma_win_xlat`

## Requirements
- R1: A window matches when it is enabled and (bus address AND NOT mask) equals its base. When several windows match, the lowest window index is used, and that index is reported on `rspWin`.
- R2: A request that matches no enabled window returns `rspError`=1, `rspAddr`=0 and `rspWin`=0.
- R3: In direct mode the host address is the window's translation field plus (bus address AND mask). The response is valid on the clock edge after the accept edge.
- R4: In scatter-gather mode the offset is (bus address AND mask) and the page is offset[18:13]. The table index is (translation field bits [5:0] + page) modulo 64. The host address is {entry frame (19 bits), bus address[12:0]}.
- R5: A table entry whose valid bit is 0 makes the response `rspError`=1 with `rspAddr`=0, and such an entry is never cached.
- R6: A scatter-gather request whose table index is held in the cache is answered on the edge after acceptance, and `reqReady` stays 1.
- R7: On a cache miss, `reqReady` is 0 for exactly one cycle after the accept edge, and the response is valid on the following edge.
- R8: A table write to an index that is held in the cache removes that entry. The next request to that page reads the SRAM and returns the new frame.
- R9: A table write on the accept edge of a request to the same index is seen by that request: it is treated as a miss and returns the written entry.
- R10: A table write to the pending index on the SRAM-read edge does not change that response, but it prevents the entry from being cached.
- R11: The cache holds four entries and replaces them in round-robin order of filling. After five fills of distinct indices, the first one misses again.
- R12: After reset, `reqReady` is 1, `rspValid` is 0, all windows are disabled, the cache is empty and every table entry is invalid.
- R13: A window configuration write takes effect for requests accepted after its edge. A request accepted on the same edge uses the old setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWrEn | input | 1 | Window configuration write strobe |
| cfgWin | input | 2 | Window index to write |
| cfgBase | input | 32 | Window match base |
| cfgMask | input | 32 | Window size mask (offset bits set) |
| cfgEnable | input | 1 | Window enable |
| cfgSgMode | input | 1 | 1 = scatter-gather, 0 = direct |
| cfgXlat | input | 32 | Direct host offset, or table index base in bits [5:0] |
| ptWrEn | input | 1 | Page-table write strobe |
| ptWrAddr | input | 6 | Page-table index |
| ptWrValid | input | 1 | Entry valid bit |
| ptWrPfn | input | 19 | Entry host page frame |
| reqValid | input | 1 | Translation request valid |
| reqAddr | input | 32 | Bus address |
| reqReady | output | 1 | Request can be accepted |
| rspValid | output | 1 | Response valid (one cycle) |
| rspAddr | output | 32 | Host address, 0 on error |
| rspError | output | 1 | No window hit or invalid entry |
| rspWin | output | 2 | Window that translated |

## Verification
The case that matters is a page-table write landing in the same cycle as a lookup of that same index. The write can fall on the accept edge, where it must win over a cached copy and be forwarded through the SRAM read. It can also fall on the SRAM-read edge, where it must leave the response unchanged but block the cache fill. The bench provokes both by driving the write port in the chosen phase of a request. A behavioural model computes the expected value on every clock, using plain arrays for the table, the cache and the windows. The model judges each cycle's response and stall, and so exposes both a stale hit and a wrongly kept fill.

// File: rtl/dmaxl_pkg.sv
package dmaxl_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic accept;   // request taken this cycle
    logic rspFast;  // answer from decode or cache on this edge
    logic waitRam;  // miss: SRAM read launched on this edge
    logic rspSlow;  // answer from SRAM read data on this edge
  } ctrlStrb_t;

  typedef enum logic {ST_IDLE = 1'b0, ST_FETCH = 1'b1} xlState_t;
endpackage

// File: rtl/dmaxl_ctrl.sv
module dmaxl_ctrl
  import dmaxl_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  input  logic      decNoHit,
  input  logic      decDirect,
  input  logic      tlbHit,
  output logic      reqReady,
  output ctrlStrb_t strb
);
  xlState_t state;
  logic answerNow;

  assign reqReady  = (state == ST_IDLE);
  assign answerNow = decNoHit || decDirect || tlbHit;

  always_comb begin
    strb.accept  = reqValid && reqReady;
    strb.rspFast = strb.accept && answerNow;
    strb.waitRam = strb.accept && !answerNow;
    strb.rspSlow = (state == ST_FETCH);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else if (strb.waitRam) state <= ST_FETCH;
    else if (state == ST_FETCH) state <= ST_IDLE;
  end
endmodule

// File: rtl/dmaxl_dpath.sv
module dmaxl_dpath
  import dmaxl_pkg::*;
#(
  parameter int NUM_WIN   = 4,
  parameter int ADDR_W    = 32,
  parameter int PAGE_BITS = 13,
  parameter int PT_AW     = 6,
  parameter int TLB_N     = 4,
  localparam int WIN_W    = $clog2(NUM_WIN),
  localparam int PFN_W    = ADDR_W - PAGE_BITS
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [WIN_W-1:0]  cfgWin,
  input  logic [ADDR_W-1:0] cfgBase,
  input  logic [ADDR_W-1:0] cfgMask,
  input  logic              cfgEnable,
  input  logic              cfgSgMode,
  input  logic [ADDR_W-1:0] cfgXlat,
  input  logic              ptWrEn,
  input  logic [PT_AW-1:0]  ptWrAddr,
  input  logic              ptWrValid,
  input  logic [PFN_W-1:0]  ptWrPfn,
  input  logic [ADDR_W-1:0] reqAddr,
  input  ctrlStrb_t         strb,
  output logic              decNoHit,
  output logic              decDirect,
  output logic              tlbHit,
  output logic              rspValid,
  output logic [ADDR_W-1:0] rspAddr,
  output logic              rspError,
  output logic [WIN_W-1:0]  rspWin
);
  localparam int PT_DEPTH = 1 << PT_AW;
  localparam int TLB_W    = (TLB_N > 1) ? $clog2(TLB_N) : 1;

  // ---------------- window registers ----------------
  logic [ADDR_W-1:0] winBase [NUM_WIN];
  logic [ADDR_W-1:0] winMask [NUM_WIN];
  logic [ADDR_W-1:0] winXlat [NUM_WIN];
  logic [NUM_WIN-1:0] winEn, winSg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_WIN; i++) begin
        winBase[i] <= '0;
        winMask[i] <= '0;
        winXlat[i] <= '0;
      end
      winEn <= '0;
      winSg <= '0;
    end else if (cfgWrEn) begin
      winBase[cfgWin] <= cfgBase;
      winMask[cfgWin] <= cfgMask;
      winXlat[cfgWin] <= cfgXlat;
      winEn[cfgWin]   <= cfgEnable;
      winSg[cfgWin]   <= cfgSgMode;
    end
  end

  // ---------------- window decode ----------------
  logic [NUM_WIN-1:0] winHitVec;
  logic [WIN_W-1:0]   selWin;
  logic               anyHit;
  logic [ADDR_W-1:0]  selOff, directAddr;
  logic [PT_AW-1:0]   ptIdx;

  for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
    assign winHitVec[g] = winEn[g] && ((reqAddr & ~winMask[g]) == winBase[g]);
  end

  always_comb begin
    selWin = '0;
    for (int i = NUM_WIN - 1; i >= 0; i--)
      if (winHitVec[i]) selWin = WIN_W'(i);
  end

  assign anyHit     = |winHitVec;
  assign selOff     = reqAddr & winMask[selWin];
  assign directAddr = winXlat[selWin] + selOff;
  assign ptIdx      = winXlat[selWin][PT_AW-1:0] + selOff[PAGE_BITS +: PT_AW];
  assign decNoHit   = !anyHit;
  assign decDirect  = anyHit && !winSg[selWin];

  // ---------------- page-table SRAM ----------------
  logic [PFN_W-1:0]    ptPfn [PT_DEPTH];
  logic [PT_DEPTH-1:0] ptVld;
  logic [PFN_W-1:0]    ramQPfn;
  logic                ramQVld;
  logic                snoopCur;

  assign snoopCur = ptWrEn && (ptWrAddr == ptIdx);

  always_ff @(posedge clk) begin
    if (ptWrEn) ptPfn[ptWrAddr] <= ptWrPfn;
    if (strb.accept) ramQPfn <= snoopCur ? ptWrPfn : ptPfn[ptIdx];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptVld   <= '0;
      ramQVld <= 1'b0;
    end else begin
      if (ptWrEn) ptVld[ptWrAddr] <= ptWrValid;
      if (strb.accept) ramQVld <= snoopCur ? ptWrValid : ptVld[ptIdx];
    end
  end

  // ---------------- pending request ----------------
  logic [PT_AW-1:0]     pendIdx;
  logic [PAGE_BITS-1:0] pendLow;
  logic [WIN_W-1:0]     pendWin;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendIdx <= '0;
      pendLow <= '0;
      pendWin <= '0;
    end else if (strb.waitRam) begin
      pendIdx <= ptIdx;
      pendLow <= reqAddr[PAGE_BITS-1:0];
      pendWin <= selWin;
    end
  end

  // ---------------- translation cache ----------------
  logic [TLB_N-1:0] tlbVld;
  logic [PT_AW-1:0] tlbTag [TLB_N];
  logic [PFN_W-1:0] tlbPfn [TLB_N];
  logic [TLB_N-1:0] tlbHitVec;
  logic [PFN_W-1:0] tlbHitPfn;
  logic [TLB_W-1:0] victim;
  logic             fillEn;

  for (genvar t = 0; t < TLB_N; t++) begin : g_tlb
    assign tlbHitVec[t] = tlbVld[t] && (tlbTag[t] == ptIdx);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        tlbVld[t] <= 1'b0;
        tlbTag[t] <= '0;
        tlbPfn[t] <= '0;
      end else if (fillEn && (victim == TLB_W'(t))) begin
        tlbVld[t] <= 1'b1;
        tlbTag[t] <= pendIdx;
        tlbPfn[t] <= ramQPfn;
      end else if (ptWrEn && (tlbTag[t] == ptWrAddr)) begin
        tlbVld[t] <= 1'b0;
      end
    end
  end

  always_comb begin
    tlbHitPfn = '0;
    for (int i = 0; i < TLB_N; i++)
      if (tlbHitVec[i]) tlbHitPfn = tlbHitPfn | tlbPfn[i];
  end

  assign tlbHit = anyHit && winSg[selWin] && (|tlbHitVec) && !snoopCur;
  assign fillEn = strb.rspSlow && ramQVld && !(ptWrEn && (ptWrAddr == pendIdx));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) victim <= '0;
    else if (fillEn) victim <= (victim == TLB_W'(TLB_N - 1)) ? '0 : victim + 1'b1;
  end

  // ---------------- response ----------------
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspAddr  <= '0;
      rspError <= 1'b0;
      rspWin   <= '0;
    end else begin
      rspValid <= strb.rspFast || strb.rspSlow;
      rspAddr  <= '0;
      rspError <= 1'b0;
      rspWin   <= '0;
      if (strb.rspSlow) begin
        rspWin   <= pendWin;
        rspError <= !ramQVld;
        if (ramQVld) rspAddr <= {ramQPfn, pendLow};
      end else if (strb.rspFast) begin
        if (!anyHit) begin
          rspError <= 1'b1;
        end else begin
          rspWin  <= selWin;
          rspAddr <= decDirect ? directAddr : {tlbHitPfn, reqAddr[PAGE_BITS-1:0]};
        end
      end
    end
  end
endmodule

// File: rtl/dma_win_xlat.sv
module dma_win_xlat
  import dmaxl_pkg::*;
#(
  parameter int NUM_WIN   = 4,
  parameter int ADDR_W    = 32,
  parameter int PAGE_BITS = 13,
  parameter int PT_AW     = 6,
  parameter int TLB_N     = 4,
  localparam int WIN_W    = $clog2(NUM_WIN),
  localparam int PFN_W    = ADDR_W - PAGE_BITS
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [WIN_W-1:0]  cfgWin,
  input  logic [ADDR_W-1:0] cfgBase,
  input  logic [ADDR_W-1:0] cfgMask,
  input  logic              cfgEnable,
  input  logic              cfgSgMode,
  input  logic [ADDR_W-1:0] cfgXlat,
  input  logic              ptWrEn,
  input  logic [PT_AW-1:0]  ptWrAddr,
  input  logic              ptWrValid,
  input  logic [PFN_W-1:0]  ptWrPfn,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic              reqReady,
  output logic              rspValid,
  output logic [ADDR_W-1:0] rspAddr,
  output logic              rspError,
  output logic [WIN_W-1:0]  rspWin
);
  ctrlStrb_t strb;
  logic decNoHit, decDirect, tlbHit;

  dmaxl_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid),
    .decNoHit(decNoHit), .decDirect(decDirect), .tlbHit(tlbHit),
    .reqReady(reqReady), .strb(strb)
  );

  dmaxl_dpath #(
    .NUM_WIN(NUM_WIN), .ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS),
    .PT_AW(PT_AW), .TLB_N(TLB_N)
  ) u_dp (
    .clk(clk), .rstN(rstN),
    .cfgWrEn(cfgWrEn), .cfgWin(cfgWin), .cfgBase(cfgBase), .cfgMask(cfgMask),
    .cfgEnable(cfgEnable), .cfgSgMode(cfgSgMode), .cfgXlat(cfgXlat),
    .ptWrEn(ptWrEn), .ptWrAddr(ptWrAddr), .ptWrValid(ptWrValid), .ptWrPfn(ptWrPfn),
    .reqAddr(reqAddr), .strb(strb),
    .decNoHit(decNoHit), .decDirect(decDirect), .tlbHit(tlbHit),
    .rspValid(rspValid), .rspAddr(rspAddr), .rspError(rspError), .rspWin(rspWin)
  );
endmodule

// File: rtl/dmaxl_chk.sv
module dmaxl_chk #(
  parameter int ADDR_W = 32,
  parameter int TLB_N  = 4
)(
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic              rspValid,
  input logic              rspError,
  input logic [ADDR_W-1:0] rspAddr,
  input logic [TLB_N-1:0]  tlbHitVec
);
  // R7
  stall_then_answer_chk: assert property (@(posedge clk) disable iff (!rstN)
    !reqReady |=> (rspValid && reqReady));

  // R6
  accept_answered_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> (rspValid || !reqReady));

  // R2
  error_addr_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspError |-> (rspAddr == '0));

  // R5
  error_only_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspError |-> rspValid);

  // R11
  tlb_unique_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(tlbHitVec));

  // R12
  idle_no_rsp_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!reqValid && reqReady) |=> !rspValid);
endmodule

bind dma_win_xlat dmaxl_chk #(.ADDR_W(ADDR_W), .TLB_N(TLB_N)) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .rspValid(rspValid), .rspError(rspError), .rspAddr(rspAddr),
  .tlbHitVec(u_dp.tlbHitVec)
);

// File: tb/dma_win_xlat_tb.sv
module dma_win_xlat_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [1:0]  cfgWin = '0;
  logic [31:0] cfgBase = '0, cfgMask = '0, cfgXlat = '0;
  logic        cfgEnable = 1'b0, cfgSgMode = 1'b0;
  logic        ptWrEn = 1'b0;
  logic [5:0]  ptWrAddr = '0;
  logic        ptWrValid = 1'b0;
  logic [18:0] ptWrPfn = '0;
  logic        reqValid = 1'b0;
  logic [31:0] reqAddr = '0;
  logic        reqReady, rspValid, rspError;
  logic [31:0] rspAddr;
  logic [1:0]  rspWin;

  int checks = 0, errors = 0;
  string phase = "R12";
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dma_win_xlat u_dut (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWin(cfgWin), .cfgBase(cfgBase),
    .cfgMask(cfgMask), .cfgEnable(cfgEnable), .cfgSgMode(cfgSgMode), .cfgXlat(cfgXlat),
    .ptWrEn(ptWrEn), .ptWrAddr(ptWrAddr), .ptWrValid(ptWrValid), .ptWrPfn(ptWrPfn),
    .reqValid(reqValid), .reqAddr(reqAddr), .reqReady(reqReady), .rspValid(rspValid),
    .rspAddr(rspAddr), .rspError(rspError), .rspWin(rspWin)
  );

  // ---------------- behavioural reference model ----------------
  logic [31:0] mBase [4], mMask [4], mXlat [4];
  bit          mEn [4], mSg [4];
  bit          mPtV [64];
  logic [18:0] mPtP [64];
  bit          mTv [4];
  int          mTt [4];
  logic [18:0] mTp [4];
  int          mPtr = 0;
  bit          mFetch = 1'b0;
  int          mPendIdx = 0, mPendWin = 0;
  bit          mPendV = 1'b0;
  logic [18:0] mPendP = '0;
  logic [12:0] mPendLow = '0;
  bit          eValid = 1'b0, eErr = 1'b0, eReady = 1'b1;
  logic [31:0] eAddr = '0;
  int          eWin = 0;

  task automatic modelReset();
    for (int i = 0; i < 4; i++) begin
      mBase[i] = '0; mMask[i] = '0; mXlat[i] = '0; mEn[i] = 0; mSg[i] = 0;
      mTv[i] = 0; mTt[i] = 0; mTp[i] = '0;
    end
    for (int i = 0; i < 64; i++) begin mPtV[i] = 0; mPtP[i] = '0; end
    mPtr = 0; mFetch = 0;
    eValid = 0; eErr = 0; eAddr = '0; eWin = 0; eReady = 1;
  endtask

  initial modelReset();

  always @(posedge clk) begin
    if (!rstN) begin
      modelReset();
    end else begin
      eValid = 0; eErr = 0; eAddr = '0; eWin = 0;
      if (mFetch) begin
        eValid = 1; eWin = mPendWin;
        if (mPendV) begin
          eAddr = {mPendP, mPendLow};
          if (!(ptWrEn && int'(ptWrAddr) == mPendIdx)) begin
            mTv[mPtr] = 1; mTt[mPtr] = mPendIdx; mTp[mPtr] = mPendP;
            mPtr = (mPtr + 1) % 4;
          end
        end else eErr = 1;
        mFetch = 0;
      end else if (reqValid) begin
        int sel;
        sel = -1;
        for (int i = 0; i < 4; i++)
          if (sel < 0 && mEn[i] && ((reqAddr & ~mMask[i]) == mBase[i])) sel = i;
        if (sel < 0) begin
          eValid = 1; eErr = 1;
        end else if (!mSg[sel]) begin
          eValid = 1; eWin = sel; eAddr = mXlat[sel] + (reqAddr & mMask[sel]);
        end else begin
          logic [31:0] off;
          int idx, hitAt;
          bit snoopNow;
          off = reqAddr & mMask[sel];
          idx = (int'(mXlat[sel] & 32'h3F) + int'((off >> 13) & 32'h3F)) % 64;
          snoopNow = ptWrEn && (int'(ptWrAddr) == idx);
          hitAt = -1;
          for (int i = 0; i < 4; i++) if (mTv[i] && mTt[i] == idx) hitAt = i;
          if (hitAt >= 0 && !snoopNow) begin
            eValid = 1; eWin = sel; eAddr = {mTp[hitAt], reqAddr[12:0]};
          end else begin
            mFetch = 1; mPendIdx = idx; mPendWin = sel; mPendLow = reqAddr[12:0];
            mPendV = snoopNow ? ptWrValid : mPtV[idx];
            mPendP = snoopNow ? ptWrPfn : mPtP[idx];
          end
        end
      end
      if (ptWrEn) begin
        for (int i = 0; i < 4; i++)
          if (mTv[i] && mTt[i] == int'(ptWrAddr) &&
              !(i == (mPtr + 3) % 4 && eValid && !eErr && mTt[i] == mPendIdx && !mFetch))
            mTv[i] = 0;
        mPtV[ptWrAddr] = ptWrValid; mPtP[ptWrAddr] = ptWrPfn;
      end
      if (cfgWrEn) begin
        mBase[cfgWin] = cfgBase; mMask[cfgWin] = cfgMask; mXlat[cfgWin] = cfgXlat;
        mEn[cfgWin] = cfgEnable; mSg[cfgWin] = cfgSgMode;
      end
      eReady = !mFetch;
    end
  end

  // ---------------- per-cycle comparison ----------------
  always @(negedge clk) begin
    if (!done) begin
      checks++;
      if (rspValid !== eValid || rspError !== eErr || rspAddr !== eAddr ||
          rspWin !== 2'(eWin) || reqReady !== eReady) begin
        errors++;
        $display("FAIL %s t=%0t: valid/err/addr/win/ready actual %b/%b/%h/%0d/%b expected %b/%b/%h/%0d/%b",
                 phase, $time, rspValid, rspError, rspAddr, rspWin, reqReady,
                 eValid, eErr, eAddr, eWin, eReady);
      end
    end
  end

  // ---------------- stimulus ----------------
  task automatic cfgWrite(input int w, input logic [31:0] b, input logic [31:0] m,
                          input bit en, input bit sg, input logic [31:0] x);
    cfgWrEn = 1; cfgWin = 2'(w); cfgBase = b; cfgMask = m; cfgEnable = en;
    cfgSgMode = sg; cfgXlat = x;
    @(negedge clk);
    cfgWrEn = 0;
  endtask

  task automatic ptWrite(input int idx, input bit v, input logic [18:0] pfn);
    ptWrEn = 1; ptWrAddr = 6'(idx); ptWrValid = v; ptWrPfn = pfn;
    @(negedge clk);
    ptWrEn = 0;
  endtask

  // wrPhase: -1 none, 0 on the accept edge, 1 on the following edge
  task automatic issue(input logic [31:0] a, input int wrPhase = -1, input int idx = 0,
                       input bit v = 0, input logic [18:0] pfn = '0);
    while (!reqReady) @(negedge clk);
    reqValid = 1; reqAddr = a;
    if (wrPhase == 0) begin ptWrEn = 1; ptWrAddr = 6'(idx); ptWrValid = v; ptWrPfn = pfn; end
    @(negedge clk);
    reqValid = 0; ptWrEn = 0;
    if (wrPhase == 1) begin ptWrEn = 1; ptWrAddr = 6'(idx); ptWrValid = v; ptWrPfn = pfn; end
    @(negedge clk);
    ptWrEn = 0;
  endtask

  task automatic burst(input logic [31:0] a0, input int n, input logic [31:0] step);
    for (int k = 0; k < n; k++) begin
      bit rdy;
      reqValid = 1; reqAddr = a0 + step * k;
      do begin rdy = reqReady; @(negedge clk); end while (!rdy);
    end
    reqValid = 0;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    // R12: empty after reset, no window enabled
    phase = "R12";
    repeat (2) @(negedge clk);
    issue(32'h1000_0000);
    // R13: configuration on the accept edge is not yet seen
    phase = "R13";
    cfgWrEn = 1; cfgWin = 0; cfgBase = 32'h1000_0000; cfgMask = 32'h000F_FFFF;
    cfgEnable = 1; cfgSgMode = 0; cfgXlat = 32'h8000_0000;
    reqValid = 1; reqAddr = 32'h1000_0040;
    @(negedge clk);
    cfgWrEn = 0; reqValid = 0;
    @(negedge clk);
    issue(32'h1000_0040);
    // R3: direct mapping
    phase = "R3";
    issue(32'h100F_FFFC);
    issue(32'h1000_0000);
    // R1: lowest index wins, disabled windows ignored
    phase = "R1";
    cfgWrite(3, 32'h1000_0000, 32'h0000_FFFF, 1, 0, 32'h4000_0000);
    issue(32'h1000_1234);
    cfgWrite(0, 32'h1000_0000, 32'h000F_FFFF, 0, 0, 32'h8000_0000);
    issue(32'h1000_1234);
    issue(32'h1001_0000);
    cfgWrite(0, 32'h1000_0000, 32'h000F_FFFF, 1, 0, 32'h8000_0000);
    issue(32'h1000_1234);
    // R2: no window
    phase = "R2";
    issue(32'h5000_0000);
    issue(32'h1010_0000);
    // R4: scatter-gather windows and table
    phase = "R4";
    cfgWrite(1, 32'h2000_0000, 32'h0007_FFFF, 1, 1, 32'h0000_0000);
    cfgWrite(2, 32'h2004_0000, 32'h0003_FFFF, 1, 1, 32'h0000_003E);
    for (int i = 0; i < 64; i++) ptWrite(i, (i != 9), 19'h4000 + 19'(i * 3));
    issue(32'h2000_0123);
    issue(32'h2000_2456);
    issue(32'h2007_FFFF);
    // R6: cache hit
    phase = "R6";
    issue(32'h2000_0FFF);
    burst(32'h2000_0010, 4, 32'h0000_2000);
    // R5: invalid entry, never cached
    phase = "R5";
    issue(32'h2001_2010);
    issue(32'h2001_2010);
    // R1 + R4: shadowed window and index wrap
    phase = "R4";
    cfgWrite(1, 32'h2000_0000, 32'h0007_FFFF, 0, 1, 32'h0000_0000);
    issue(32'h2004_6000);
    issue(32'h2004_0ABC);
    cfgWrite(1, 32'h2000_0000, 32'h0007_FFFF, 1, 1, 32'h0000_0000);
    // R11: round-robin replacement
    phase = "R11";
    for (int p = 10; p < 15; p++) issue(32'h2000_0000 + 32'(p) * 32'h2000);
    issue(32'h2000_0000 + 32'd10 * 32'h2000);
    issue(32'h2000_0000 + 32'd14 * 32'h2000);
    // R7: miss stall in a held-valid stream
    phase = "R7";
    burst(32'h2000_0000 + 32'd40 * 32'h2000, 6, 32'h0000_2000);
    // R8: snooped write replaces cached translation
    phase = "R8";
    issue(32'h2000_0000 + 32'd20 * 32'h2000);
    ptWrite(20, 1, 19'h7_1111);
    issue(32'h2000_0000 + 32'd20 * 32'h2000 + 32'h44);
    ptWrite(21, 1, 19'h7_2222);
    issue(32'h2000_0000 + 32'd20 * 32'h2000 + 32'h48);
    // R9: write on the accept edge is forwarded
    phase = "R9";
    issue(32'h2000_0000 + 32'd20 * 32'h2000, 0, 20, 1, 19'h3_3333);
    issue(32'h2000_0000 + 32'd20 * 32'h2000 + 32'h8);
    issue(32'h2000_0000 + 32'd22 * 32'h2000, 0, 22, 0, 19'h0);
    // R10: write during SRAM read neither changes nor caches
    phase = "R10";
    issue(32'h2000_0000 + 32'd30 * 32'h2000, 1, 30, 1, 19'h5_5555);
    issue(32'h2000_0000 + 32'd30 * 32'h2000 + 32'h4);
    issue(32'h2000_0000 + 32'd30 * 32'h2000 + 32'h8);
    issue(32'h2000_0000 + 32'd31 * 32'h2000, 1, 5, 0, 19'h0);
    issue(32'h2000_0000 + 32'd31 * 32'h2000);
    repeat (4) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: actual hung run, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule